// File: doc/BRIEF.md
# Transmit Frame Writer for a Shared Circular Buffer

The block is the producer side of a transmit path that hands frames to a consuming device through two circular structures in shared memory. One is a data buffer of 16-bit words; the other is a nine-slot ring of control words that describe each frame. A frame arrives as a command (byte count, line mode, end-of-frame and abort flags) followed by a stream of bytes. The block bit-reverses every byte and packs them two to a word, the earlier byte in the upper half. It writes the words at consecutive buffer locations, wrapping to the start after the last location, and advances its write pointer.

Once every word of a frame is in memory, the block posts one control word describing the frame into the next ring slot and advances the ring write index. The consumer owns both read positions. The block reads them to decide whether a frame fits and whether a ring slot is free, and it holds off until they are. Commands that cannot ever be satisfied are refused at once with a one-cycle reject pulse.

Top module: `ftx_writer`

## Requirements
- R1: Each data word is {reverse(first byte), reverse(second byte)}, where reverse maps bit i of a byte to bit 7-i; the first byte of a pair occupies bits 15:8.
- R2: For a frame with an odd byte count, the final word carries the reversed last byte in bits 15:8 and zero in bits 7:0.
- R3: Data word k of the buffer is written at address cfg_base + wr_ptr; wr_ptr rises by one per word and returns from cfg_len-1 to 0, so a frame crossing the end is split into a tail part and a part starting at cfg_base. wr_ptr does not change without a data write.
- R4: Free space is (rd_ptr - wr_ptr - 1) modulo cfg_len, so one slot always stays empty and rd_ptr = wr_ptr means empty. A frame of W = ceil(len/2) words waits until W <= free space; while waiting, byte_ready stays 0 and no data word is written.
- R5: The control word is bits 15:14 = 0, bit 13 = abort, bit 12 = end of frame, bit 11 = 0, bits 10:9 = mode as given on cmd_mode (00 asynchronous, 10 HDLC, 01 raw bitstream, 11 asynchronous with extra stop bits), bits 8:0 = frame length in bytes.
- R6: Exactly one control word is written per accepted frame, including a zero-length frame, at cfg_ring_base + ring_wr, and only after all of that frame's data words have been written.
- R7: ring_wr counts 0..8 and wraps from 8 to 0; a post waits while the incremented index would equal ring_rd, and ring_wr does not change while it waits.
- R8: A command with a length above 511 or needing more than cfg_len-1 words is refused: cmd_reject is 1 for the one cycle after acceptance, no byte is taken, no write occurs and both write positions stay unchanged.
- R9: After reset wr_ptr = 0, ring_wr = 0, cmd_ready = 1, byte_ready = 0 and neither write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW (10) | Word address of data buffer start |
| cfg_len | input | PW (9) | Data buffer length in words (at least 2) |
| cfg_ring_base | input | AW (10) | Word address of control ring slot 0 |
| rd_ptr | input | PW (9) | Consumer read offset in the data buffer |
| wr_ptr | output | PW (9) | Producer write offset in the data buffer |
| ring_rd | input | RIW (4) | Consumer read index of the control ring |
| ring_wr | output | RIW (4) | Producer write index of the control ring |
| cmd_valid | input | 1 | Frame command present |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_len | input | LEN_W (10) | Frame length in bytes |
| cmd_mode | input | 2 | Line mode code copied into the control word |
| cmd_eof | input | 1 | Frame ends a message |
| cmd_abort | input | 1 | Frame is an abort |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |
| byte_valid | input | 1 | Payload byte present |
| byte_ready | output | 1 | Payload byte taken on this edge when valid |
| byte_data | input | 8 | Payload byte |
| dmem_we | output | 1 | Data buffer write strobe |
| dmem_addr | output | AW (10) | Data buffer write address |
| dmem_wdata | output | 16 | Packed data word |
| cmem_we | output | 1 | Control ring write strobe |
| cmem_addr | output | AW (10) | Control ring write address |
| cmem_wdata | output | 16 | Control word |

## Verification
The hardest states to reach are the two stalls, because the consumer normally keeps up. The bench models the consumer and withholds progress on purpose: it places rd_ptr three words ahead of the write position so that a five-word frame must wait, and it freezes ring_rd over eight posts so that the ninth frame's data lands but its control word must wait. Frames of 15 bytes in a 20-word buffer make the data pointer wrap inside a frame, and a 38-byte frame fills exactly the largest admissible span.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    localparam int FLEN_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPACE = 2'd1,
        ST_DATA  = 2'd2,
        ST_RING  = 2'd3
    } ftx_state_e;

    typedef enum logic [1:0] {
        MODE_ASYNC       = 2'b00,
        MODE_RAW         = 2'b01,
        MODE_HDLC        = 2'b10,
        MODE_ASYNC_XSTOP = 2'b11
    } ftx_mode_e;

    typedef struct packed {
        logic              abort;
        logic              eof;
        ftx_mode_e         mode;
        logic [FLEN_W-1:0] len;
    } ftx_frame_t;

    function automatic logic [7:0] bit_rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = b[7-i];
        end
        return r;
    endfunction

    function automatic logic [15:0] make_cw(input ftx_frame_t f);
        return {2'b00, f.abort, f.eof, 1'b0, f.mode, f.len};
    endfunction

endpackage

// File: rtl/ftx_packer.sv
module ftx_packer
    import ftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FLEN_W-1:0] start_len,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic              word_we,
    output logic [15:0]       word,
    output logic [FLEN_W-1:0] left
);

    typedef struct packed {
        logic [7:0]        hi;
        logic              hi_vld;
        logic [FLEN_W-1:0] cnt;
    } pk_regs_t;

    pk_regs_t q, d;
    logic [7:0] rb;
    logic       last;

    always_comb begin
        d       = q;
        word_we = 1'b0;
        word    = '0;
        rb      = bit_rev8(byte_in);
        last    = (q.cnt == FLEN_W'(1));
        if (start) begin
            d.cnt    = start_len;
            d.hi_vld = 1'b0;
        end else if (take) begin
            d.cnt = q.cnt - 1'b1;
            if (q.hi_vld) begin
                word_we  = 1'b1;
                word     = {q.hi, rb};
                d.hi_vld = 1'b0;
            end else if (last) begin
                word_we = 1'b1;
                word    = {rb, 8'h00};
            end else begin
                d.hi     = rb;
                d.hi_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign left = q.cnt;

endmodule

// File: rtl/ftx_space.sv
module ftx_space #(
    parameter int PW = 9
) (
    input  logic [PW-1:0] wr,
    input  logic [PW-1:0] rd,
    input  logic [PW-1:0] len,
    input  logic [PW-1:0] need,
    output logic          fits
);

    logic [PW:0] wr_e;
    logic [PW:0] rd_e;
    logic [PW:0] len_e;
    logic [PW:0] free;

    always_comb begin
        wr_e  = {1'b0, wr};
        rd_e  = {1'b0, rd};
        len_e = {1'b0, len};
        if (rd_e > wr_e) begin
            free = rd_e - wr_e - 1'b1;
        end else begin
            free = len_e - wr_e + rd_e - 1'b1;
        end
        fits = ({1'b0, need} <= free);
    end

endmodule

// File: rtl/ftx_ring_idx.sv
module ftx_ring_idx #(
    parameter int DEPTH = 9,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [IW-1:0] widx,
    input  logic [IW-1:0] ridx,
    output logic [IW-1:0] nxt,
    output logic          full
);

    always_comb begin
        if (widx == IW'(DEPTH - 1)) begin
            nxt = '0;
        end else begin
            nxt = widx + 1'b1;
        end
        full = (nxt == ridx);
    end

endmodule

// File: rtl/ftx_writer.sv
module ftx_writer
    import ftx_pkg::*;
#(
    parameter int AW         = 10,
    parameter int PW         = 9,
    parameter int LEN_W      = 10,
    parameter int RING_DEPTH = 9,
    localparam int RIW       = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_base,
    input  logic [PW-1:0]    cfg_len,
    input  logic [AW-1:0]    cfg_ring_base,
    input  logic [PW-1:0]    rd_ptr,
    output logic [PW-1:0]    wr_ptr,
    input  logic [RIW-1:0]   ring_rd,
    output logic [RIW-1:0]   ring_wr,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [1:0]       cmd_mode,
    input  logic             cmd_eof,
    input  logic             cmd_abort,
    output logic             cmd_reject,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    output logic             dmem_we,
    output logic [AW-1:0]    dmem_addr,
    output logic [15:0]      dmem_wdata,
    output logic             cmem_we,
    output logic [AW-1:0]    cmem_addr,
    output logic [15:0]      cmem_wdata
);

    localparam int CW      = ((LEN_W > PW) ? LEN_W : PW) + 1;
    localparam int MAX_LEN = (1 << FLEN_W) - 1;

    typedef struct packed {
        ftx_state_e     st;
        ftx_frame_t     fr;
        logic [PW-1:0]  words;
        logic [PW-1:0]  wr;
        logic [RIW-1:0] rwr;
        logic           rej;
    } regs_t;

    regs_t q, d;

    logic              pk_start;
    logic              pk_take;
    logic              pk_we;
    logic [15:0]       pk_word;
    logic [FLEN_W-1:0] pk_left;
    logic              sp_fits;
    logic [RIW-1:0]    rg_nxt;
    logic              rg_full;
    logic [PW-1:0]     wr_nxt;
    logic [CW-1:0]     wreq;
    logic [CW-1:0]     cap;
    logic              too_long;
    logic              post;

    ftx_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pk_start),
        .start_len (cmd_len[FLEN_W-1:0]),
        .take      (pk_take),
        .byte_in   (byte_data),
        .word_we   (pk_we),
        .word      (pk_word),
        .left      (pk_left)
    );

    ftx_space #(.PW(PW)) u_space (
        .wr   (q.wr),
        .rd   (rd_ptr),
        .len  (cfg_len),
        .need (q.words),
        .fits (sp_fits)
    );

    ftx_ring_idx #(.DEPTH(RING_DEPTH)) u_ring (
        .widx (q.rwr),
        .ridx (ring_rd),
        .nxt  (rg_nxt),
        .full (rg_full)
    );

    assign byte_ready = (q.st == ST_DATA) && (pk_left != '0);
    assign pk_take    = byte_valid && byte_ready;
    assign wr_nxt     = (q.wr == cfg_len - 1'b1) ? '0 : q.wr + 1'b1;

    always_comb begin
        d        = q;
        d.rej    = 1'b0;
        pk_start = 1'b0;
        post     = 1'b0;
        wreq     = (CW'(cmd_len) + CW'(1)) >> 1;
        cap      = CW'(cfg_len) - CW'(1);
        too_long = (cmd_len > LEN_W'(MAX_LEN));
        if (pk_we) begin
            d.wr = wr_nxt;
        end
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (too_long || (wreq > cap)) begin
                        d.rej = 1'b1;
                    end else begin
                        d.fr.abort = cmd_abort;
                        d.fr.eof   = cmd_eof;
                        d.fr.mode  = ftx_mode_e'(cmd_mode);
                        d.fr.len   = cmd_len[FLEN_W-1:0];
                        d.words    = PW'(wreq);
                        pk_start   = 1'b1;
                        d.st       = ST_SPACE;
                    end
                end
            end
            ST_SPACE: begin
                if (sp_fits) begin
                    d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (pk_left == '0) begin
                    d.st = ST_RING;
                end
            end
            ST_RING: begin
                if (!rg_full) begin
                    post  = 1'b1;
                    d.rwr = rg_nxt;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = (q.st == ST_IDLE);
    assign cmd_reject = q.rej;
    assign wr_ptr     = q.wr;
    assign ring_wr    = q.rwr;
    assign dmem_we    = pk_we;
    assign dmem_addr  = cfg_base + AW'(q.wr);
    assign dmem_wdata = pk_word;
    assign cmem_we    = post;
    assign cmem_addr  = cfg_ring_base + AW'(q.rwr);
    assign cmem_wdata = make_cw(q.fr);

endmodule

// File: rtl/ftx_writer_chk.sv
module ftx_writer_chk #(
    parameter int AW         = 10,
    parameter int PW         = 9,
    parameter int RING_DEPTH = 9,
    localparam int RIW       = $clog2(RING_DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  cfg_base,
    input logic [PW-1:0]  cfg_len,
    input logic [AW-1:0]  cfg_ring_base,
    input logic [PW-1:0]  rd_ptr,
    input logic [PW-1:0]  wr_ptr,
    input logic [RIW-1:0] ring_rd,
    input logic [RIW-1:0] ring_wr,
    input logic           cmd_reject,
    input logic           dmem_we,
    input logic [AW-1:0]  dmem_addr,
    input logic           cmem_we,
    input logic [AW-1:0]  cmem_addr,
    input logic [15:0]    cmem_wdata
);

    logic [PW-1:0]  wcnt;
    logic [PW-1:0]  wr_inc;
    logic [RIW-1:0] ring_inc;
    logic [PW-1:0]  cw_words;

    assign wr_inc   = (wr_ptr == cfg_len - 1'b1) ? '0 : wr_ptr + 1'b1;
    assign ring_inc = (ring_wr == RIW'(RING_DEPTH - 1)) ? '0 : ring_wr + 1'b1;
    assign cw_words = PW'((10'(cmem_wdata[8:0]) + 10'd1) >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (cmem_we) begin
            wcnt <= '0;
        end else if (dmem_we) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> ((dmem_addr - cfg_base) < AW'(cfg_len)));

    p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (wr_ptr == (($past(wr_ptr) == $past(cfg_len) - 1'b1) ? '0 : $past(wr_ptr) + 1'b1)));

    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dmem_we |=> $stable(wr_ptr));

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (wr_inc != rd_ptr));

    p_cw_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmem_we |-> (cmem_wdata[15:14] == 2'b00 && cmem_wdata[11] == 1'b0));

    p_data_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmem_we |-> (wcnt == cw_words));

    p_ring_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmem_we |-> ((cmem_addr - cfg_ring_base) < AW'(RING_DEPTH)));

    p_ring_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmem_we |-> (ring_inc != ring_rd));

    p_ring_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmem_we |=> $stable(ring_wr));

    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!dmem_we && !cmem_we));

endmodule

bind ftx_writer ftx_writer_chk #(
    .AW         (AW),
    .PW         (PW),
    .RING_DEPTH (RING_DEPTH)
) u_ftx_writer_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_base      (cfg_base),
    .cfg_len       (cfg_len),
    .cfg_ring_base (cfg_ring_base),
    .rd_ptr        (rd_ptr),
    .wr_ptr        (wr_ptr),
    .ring_rd       (ring_rd),
    .ring_wr       (ring_wr),
    .cmd_reject    (cmd_reject),
    .dmem_we       (dmem_we),
    .dmem_addr     (dmem_addr),
    .cmem_we       (cmem_we),
    .cmem_addr     (cmem_addr),
    .cmem_wdata    (cmem_wdata)
);

// File: tb/tb_ftx_writer.sv
module tb_ftx_writer;

    localparam int AW    = 10;
    localparam int PW    = 9;
    localparam int LEN_W = 10;
    localparam int RD    = 9;
    localparam int RIW   = 4;
    localparam int BUF   = 20;
    localparam logic [AW-1:0] BASE  = 10'h100;
    localparam logic [AW-1:0] RBASE = 10'h3F0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    cfg_base = BASE;
    logic [PW-1:0]    cfg_len = PW'(BUF);
    logic [AW-1:0]    cfg_ring_base = RBASE;
    logic [PW-1:0]    rd_ptr = '0;
    logic [PW-1:0]    wr_ptr;
    logic [RIW-1:0]   ring_rd = '0;
    logic [RIW-1:0]   ring_wr;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [1:0]       cmd_mode = '0;
    logic             cmd_eof = 1'b0;
    logic             cmd_abort = 1'b0;
    logic             cmd_reject;
    logic             byte_valid = 1'b0;
    logic             byte_ready;
    logic [7:0]       byte_data = '0;
    logic             dmem_we;
    logic [AW-1:0]    dmem_addr;
    logic [15:0]      dmem_wdata;
    logic             cmem_we;
    logic [AW-1:0]    cmem_addr;
    logic [15:0]      cmem_wdata;

    ftx_writer #(.AW(AW), .PW(PW), .LEN_W(LEN_W), .RING_DEPTH(RD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_ring_base(cfg_ring_base), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .ring_rd(ring_rd), .ring_wr(ring_wr), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_len(cmd_len), .cmd_mode(cmd_mode),
        .cmd_eof(cmd_eof), .cmd_abort(cmd_abort), .cmd_reject(cmd_reject),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .cmem_we(cmem_we), .cmem_addr(cmem_addr), .cmem_wdata(cmem_wdata)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit mon_on = 1'b0;

    // consumer model state
    int pw = 0;   // push-side data offset
    int prw = 0;  // push-side ring index
    int mw = 0;   // observed data offset
    int mrw = 0;  // observed ring index
    bit hold_ring = 1'b0;
    logic [AW-1:0] exp_addr[$];
    logic [15:0]   exp_word[$];
    logic [AW-1:0] exp_caddr[$];
    logic [15:0]   exp_cw[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] flip(input logic [7:0] v);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    function automatic string tag_of_word(input logic [15:0] w);
        return (w[7:0] == 8'h00) ? "R1/R2" : "R1";
    endfunction

    // per-clock comparison against the consumer model
    always @(negedge clk) begin
        if (mon_on) begin
            chk(wr_ptr == PW'(mw), "R3", "wr_ptr", 32'(wr_ptr), 32'(mw));
            chk(ring_wr == RIW'(mrw), "R7", "ring_wr", 32'(ring_wr), 32'(mrw));
            if (dmem_we) begin
                if (exp_word.size() == 0) begin
                    chk(1'b0, "R6", "unexpected data write", 32'(dmem_addr), 32'hFFFF);
                end else begin
                    logic [AW-1:0] ea;
                    logic [15:0]   ew;
                    ea = exp_addr.pop_front();
                    ew = exp_word.pop_front();
                    chk(dmem_addr == ea, "R3", "dmem_addr", 32'(dmem_addr), 32'(ea));
                    chk(dmem_wdata == ew, tag_of_word(ew), "dmem_wdata", 32'(dmem_wdata), 32'(ew));
                end
                mw = (mw + 1) % BUF;
            end
            if (cmem_we) begin
                chk(exp_word.size() == 0, "R6", "data words pending at post",
                    32'(exp_word.size()), 32'd0);
                if (exp_cw.size() == 0) begin
                    chk(1'b0, "R6", "unexpected control write", 32'(cmem_addr), 32'hFFFF);
                end else begin
                    logic [AW-1:0] ca;
                    logic [15:0]   cw;
                    ca = exp_caddr.pop_front();
                    cw = exp_cw.pop_front();
                    chk(cmem_addr == ca, "R6", "cmem_addr", 32'(cmem_addr), 32'(ca));
                    chk(cmem_wdata == cw, "R5", "cmem_wdata", 32'(cmem_wdata), 32'(cw));
                end
                mrw = (mrw + 1) % RD;
            end
        end
    end

    task automatic send_frame(input int len, input logic [1:0] mode, input logic eof,
                              input logic abt, input int seed, input int gap);
        logic [7:0] b[$];
        int  words;
        bit  rej;
        words = (len + 1) / 2;
        rej   = (len > 511) || (words > BUF - 1);
        for (int i = 0; i < len; i++) b.push_back(8'((seed * 13 + i * 29 + 7) & 255));
        if (!rej) begin
            for (int w = 0; w < words; w++) begin
                logic [7:0] lo;
                lo = (2 * w + 1 < len) ? flip(b[2 * w + 1]) : 8'h00;
                exp_addr.push_back(BASE + AW'(pw));
                exp_word.push_back({flip(b[2 * w]), lo});
                pw = (pw + 1) % BUF;
            end
            exp_caddr.push_back(RBASE + AW'(prw));
            exp_cw.push_back({2'b00, abt, eof, 1'b0, mode, 9'(len)});
            prw = (prw + 1) % RD;
        end
        cmd_valid = 1'b1;
        cmd_len   = LEN_W'(len);
        cmd_mode  = mode;
        cmd_eof   = eof;
        cmd_abort = abt;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        chk(cmd_reject == rej, "R8", "cmd_reject", 32'(cmd_reject), 32'(rej));
        if (!rej) begin
            for (int i = 0; i < len; i++) begin
                byte_valid = 1'b1;
                byte_data  = b[i];
                while (!byte_ready) @(negedge clk);
                @(posedge clk);
                #1 byte_valid = 1'b0;
                if (gap > 0 && (i % 3) == 1) begin
                    repeat (gap) @(posedge clk);
                    #1;
                end
            end
            while (exp_cw.size() != 0) @(negedge clk);
        end else begin
            repeat (3) @(negedge clk);
            chk(exp_cw.size() == 0 && wr_ptr == PW'(mw), "R8", "state after reject",
                32'(wr_ptr), 32'(mw));
        end
        rd_ptr = PW'(mw);
        if (!hold_ring) ring_rd = RIW'(mrw);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(wr_ptr == '0, "R9", "wr_ptr after reset", 32'(wr_ptr), 0);
        chk(ring_wr == '0, "R9", "ring_wr after reset", 32'(ring_wr), 0);
        chk(cmd_ready == 1'b1, "R9", "cmd_ready after reset", 32'(cmd_ready), 1);
        chk(byte_ready == 1'b0, "R9", "byte_ready after reset", 32'(byte_ready), 0);
        chk(!dmem_we && !cmem_we, "R9", "write strobes after reset", 32'({dmem_we, cmem_we}), 0);
        mon_on = 1'b1;

        // R1 even frame, R5 HDLC code 10 with end of frame
        send_frame(4, 2'b10, 1'b1, 1'b0, 1, 0);
        // R2 odd frame, raw code 01
        send_frame(5, 2'b01, 1'b0, 1'b0, 2, 2);
        // R5/R6 zero-length abort, asynchronous code 00
        send_frame(0, 2'b00, 1'b0, 1'b1, 3, 0);
        // R5 extra stop bits code 11, odd length of one
        send_frame(1, 2'b11, 1'b1, 1'b0, 4, 0);
        // R3 wrap inside frames: 15 bytes = 8 words in a 20-word buffer
        for (int k = 0; k < 4; k++) send_frame(15, 2'b10, k[0], 1'b0, 10 + k, k);

        // R8 refused commands: length above 511, span above cfg_len-1
        send_frame(600, 2'b10, 1'b1, 1'b0, 5, 0);
        send_frame(40, 2'b10, 1'b1, 1'b0, 6, 0);
        // R4 boundary: 19 words fills the whole admissible span
        send_frame(38, 2'b01, 1'b1, 1'b0, 7, 0);

        // R4 stall on data space: free = 2, frame needs 5 words
        rd_ptr = PW'((mw + 3) % BUF);
        fork
            send_frame(10, 2'b00, 1'b1, 1'b0, 8, 1);
            begin
                repeat (30) begin
                    @(negedge clk);
                    chk(!byte_ready && !dmem_we, "R4", "activity while short of space",
                        32'({byte_ready, dmem_we}), 0);
                end
                rd_ptr = PW'(mw);
            end
        join

        // R7 ring full: freeze the ring reader over eight posts, ninth waits
        hold_ring = 1'b1;
        for (int k = 0; k < 8; k++) send_frame(2, 2'b10, 1'b0, 1'b0, 20 + k, 0);
        fork
            send_frame(3, 2'b10, 1'b1, 1'b0, 30, 0);
            begin
                while (exp_word.size() != 0 || exp_cw.size() == 0) @(negedge clk);
                repeat (20) begin
                    @(negedge clk);
                    chk(!cmem_we, "R7", "post while ring full", 32'(cmem_we), 0);
                end
                ring_rd = RIW'((int'(ring_rd) + 1) % RD);
            end
        join
        hold_ring = 1'b0;
        ring_rd = RIW'(mrw);

        // wrap of the ring index once more with draining consumer
        for (int k = 0; k < 3; k++) send_frame(7, 2'b00, 1'b1, 1'b0, 40 + k, 1);

        repeat (5) @(negedge clk);
        chk(exp_word.size() == 0 && exp_cw.size() == 0, "R6", "leftover expectations",
            32'(exp_word.size() + exp_cw.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule